// File: doc/BRIEF.md
# Complex Stream Mixer with Selectable Output Mode

This block is one stage of a down-conversion path. It joins two streaming inputs, a complex sample stream and a complex local-oscillator stream, and produces a single complex output stream. Every sample is a signed 16-bit I/Q pair carried in a 32-bit word, with I in bits 15:0 and Q in bits 31:16. Both values use Q1.15 format.

A small register port holds a two-bit mode. The mode chooses what the output carries. It can carry the input samples unchanged, the complex product of sample and oscillator, the oscillator samples alone, or constant zeros. In every mode an output beat is made only when both inputs offer a beat at the same time. Both inputs are then consumed together. Every beat passes through the same two-stage pipeline, so the latency does not depend on the mode. Backpressure on the output stalls the whole pipeline and both inputs.

Top module: `stream_mixer`

## Requirements
- R1: After reset, the mode reads back as 0 (pass), `m_valid` is 0, and no output beat appears until inputs are accepted.
- R2: A write to register offset 0 stores `reg_wdata[1:0]` as the mode. Reading offset 0 returns the mode in bits 1:0 and zeros in bits 31:2. Writes to any other offset leave the mode unchanged, and reads of any other offset return 0.
- R3: Mode 0 (pass) outputs the sample word unchanged.
- R4: Mode 1 (mix) outputs I = Id·Io − Qd·Qo and Q = Id·Qo + Qd·Io. Each sum is taken at full precision, rounded half-up (add 2^14, then arithmetic shift right by 15) and saturated to the range −32768..32767.
- R5: Mode 2 (oscillator) outputs the oscillator word unchanged.
- R6: Mode 3 (zero) outputs a data word of 0, while the handshake and the beat count stay the same as in the other modes.
- R7: A beat is accepted only on a clock edge where both `s_d_valid` and `s_o_valid` are high and the pipeline can advance. The two ready outputs are never high for a transfer on one side alone.
- R8: While `m_valid` is high and `m_ready` is low, `m_valid` and `m_data` hold steady, and no further input is accepted once both stages are full. Beats leave in the order they were accepted.
- R9: A beat accepted on rising edge k shows `m_valid` high after edge k+1 and not before, when the output is not stalled.
- R10: A beat is processed in the mode held just before its acceptance edge. A mode write on that same edge applies only to later beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| s_d_valid | input | 1 | Sample stream valid |
| s_d_ready | output | 1 | Sample stream ready |
| s_d_data | input | 32 | Sample {Q,I} |
| s_o_valid | input | 1 | Oscillator stream valid |
| s_o_ready | output | 1 | Oscillator stream ready |
| s_o_data | input | 32 | Oscillator {Q,I} |
| m_valid | output | 1 | Output stream valid |
| m_ready | input | 1 | Output stream ready |
| m_data | output | 32 | Output {Q,I} |

## Verification
The hardest situation to reach from the ports is a mode write that lands on the same clock edge as a beat being accepted. This is where a design that samples the mode late would give the wrong output. The bench drives the register write and both valid inputs on the same falling edge, so acceptance and the write share one rising edge. It then checks that this beat follows the old mode and the next beat follows the new one. The second hard case is a full pipeline under backpressure, which takes two beats in a row while `m_ready` is low. The bench builds it from back-to-back sends, then holds the output stalled for several cycles before releasing it.

// File: rtl/mixer_pkg.sv
package mixer_pkg;
    localparam int SW = 16;
    localparam int PW = 2 * SW;

    typedef enum logic [1:0] {
        MODE_PASS = 2'd0,
        MODE_MIX  = 2'd1,
        MODE_OSC  = 2'd2,
        MODE_ZERO = 2'd3
    } mix_mode_e;

    typedef struct packed {
        logic signed [SW-1:0] q;
        logic signed [SW-1:0] i;
    } iq_t;

    typedef struct packed {
        logic signed [PW-1:0] ii;
        logic signed [PW-1:0] qq;
        logic signed [PW-1:0] iq;
        logic signed [PW-1:0] qi;
    } prod_t;

    // Round half-up from Q2.30 sum to Q1.15, then saturate.
    function automatic logic signed [SW-1:0] round_sat(input logic signed [PW:0] acc);
        logic signed [PW:0] t;
        t = (acc + (PW+1)'(1 <<< (SW - 2))) >>> (SW - 1);
        if (t > (PW+1)'((1 <<< (SW - 1)) - 1))
            return {1'b0, {(SW-1){1'b1}}};
        else if (t < -(PW+1)'(1 <<< (SW - 1)))
            return {1'b1, {(SW-1){1'b0}}};
        else
            return t[SW-1:0];
    endfunction
endpackage

// File: rtl/mixer_ctrl.sv
module mixer_ctrl
    import mixer_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wen,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    output mix_mode_e     mode
);
    localparam logic [AW-1:0] MODE_OFS = '0;

    logic hit;
    assign hit = (addr == MODE_OFS);

    always_ff @(posedge clk) begin
        if (rst)
            mode <= MODE_PASS;
        else if (wen && hit)
            mode <= mix_mode_e'(wdata[1:0]);
    end

    always_comb begin
        rdata = '0;
        if (hit)
            rdata[1:0] = mode;
    end

    // R2: stored mode follows a write to offset 0
    p_mode_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wen && hit) |=> (mode == mix_mode_e'($past(wdata[1:0]))));

    // R2: other offsets leave the mode alone
    p_mode_keep_r2: assert property (@(posedge clk) disable iff (rst)
        (!(wen && hit)) |=> $stable(mode));
endmodule

// File: rtl/mixer_cmul.sv
module mixer_cmul
    import mixer_pkg::*;
(
    input  logic clk,
    input  logic en,
    input  iq_t  a,
    input  iq_t  b,
    output iq_t  y
);
    prod_t pr;

    always_ff @(posedge clk) begin
        if (en) begin
            pr.ii <= a.i * b.i;
            pr.qq <= a.q * b.q;
            pr.iq <= a.i * b.q;
            pr.qi <= a.q * b.i;
        end
    end

    logic signed [PW:0] sum_i, sum_q;
    always_comb begin
        sum_i = (PW+1)'(pr.ii) - (PW+1)'(pr.qq);
        sum_q = (PW+1)'(pr.iq) + (PW+1)'(pr.qi);
        y.i   = round_sat(sum_i);
        y.q   = round_sat(sum_q);
    end
endmodule

// File: rtl/stream_mixer.sv
module stream_mixer
    import mixer_pkg::*;
#(
    parameter int REG_AW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              s_d_valid,
    output logic              s_d_ready,
    input  logic [PW-1:0]     s_d_data,
    input  logic              s_o_valid,
    output logic              s_o_ready,
    input  logic [PW-1:0]     s_o_data,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [PW-1:0]     m_data
);
    mix_mode_e mode;

    mixer_ctrl #(.AW(REG_AW)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .addr  (reg_addr),
        .wen   (reg_wen),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .mode  (mode)
    );

    logic adv, fire;
    assign adv       = !m_valid || m_ready;
    assign fire      = s_d_valid && s_o_valid && adv;
    assign s_d_ready = adv && s_o_valid;
    assign s_o_ready = adv && s_d_valid;

    // Stage 1: operands and mode captured with the beat
    logic      v1;
    iq_t       d1, o1;
    mix_mode_e mode1;
    iq_t       mix_y;

    mixer_cmul u_cmul (
        .clk (clk),
        .en  (fire),
        .a   (iq_t'(s_d_data)),
        .b   (iq_t'(s_o_data)),
        .y   (mix_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            v1    <= 1'b0;
            d1    <= '0;
            o1    <= '0;
            mode1 <= MODE_PASS;
        end else if (adv) begin
            v1 <= fire;
            if (fire) begin
                d1    <= iq_t'(s_d_data);
                o1    <= iq_t'(s_o_data);
                mode1 <= mode;
            end
        end
    end

    // Stage 2: output selection
    iq_t       sel;
    mix_mode_e mode2;
    always_comb begin
        unique case (mode1)
            MODE_PASS: sel = d1;
            MODE_MIX:  sel = mix_y;
            MODE_OSC:  sel = o1;
            default:   sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            m_valid <= 1'b0;
            m_data  <= '0;
            mode2   <= MODE_PASS;
        end else if (adv) begin
            m_valid <= v1;
            if (v1) begin
                m_data <= sel;
                mode2  <= mode1;
            end
        end
    end

    // R1: nothing valid on the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> !m_valid);

    // R6: zero mode beats carry zero data
    p_zero_out_r6: assert property (@(posedge clk) disable iff (rst)
        (m_valid && mode2 == MODE_ZERO) |-> (m_data == '0));

    // R7: the two inputs transfer together
    p_joint_take_r7: assert property (@(posedge clk) disable iff (rst)
        (s_d_valid && s_d_ready) |-> (s_o_valid && s_o_ready));

    // R8: stalled output holds
    p_hold_out_r8: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

    // R9: an accepted beat occupies stage 1 on the next cycle
    p_stage_fill_r9: assert property (@(posedge clk) disable iff (rst)
        fire |=> v1);
endmodule

// File: tb/stream_mixer_test.sv
module stream_mixer_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        s_d_valid = 1'b0, s_o_valid = 1'b0, m_ready = 1'b1;
    logic        s_d_ready, s_o_ready, m_valid;
    logic [31:0] s_d_data = '0, s_o_data = '0, m_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stream_mixer #(.REG_AW(4)) uut (
        .clk(clk), .rst(rst),
        .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .s_d_valid(s_d_valid), .s_d_ready(s_d_ready), .s_d_data(s_d_data),
        .s_o_valid(s_o_valid), .s_o_ready(s_o_ready), .s_o_data(s_o_data),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
    );

    // {mode, sample, oscillator}
    localparam logic [65:0] VEC [NV] = '{
        {2'd0, 32'h1234_ABCD, 32'h7FFF_0001},
        {2'd2, 32'h1234_ABCD, 32'h7FFF_0001},
        {2'd3, 32'h1234_ABCD, 32'h7FFF_0001},
        {2'd1, 32'h0000_4000, 32'h0000_4000},
        {2'd1, 32'h2000_1000, 32'hC000_3000},
        {2'd1, 32'h8000_8000, 32'h8000_8000},
        {2'd1, 32'h7FFF_7FFF, 32'h7FFF_8000},
        {2'd1, 32'hF123_0ABC, 32'h5A5A_A5A5}
    };

    function automatic longint rs(input longint x);
        longint t;
        t = (x + 16384) >>> 15;
        if (t > 32767) t = 32767;
        if (t < -32768) t = -32768;
        return t;
    endfunction

    function automatic logic [31:0] model(input logic [1:0] m, input logic [31:0] d, input logic [31:0] o);
        longint di, dq, oi, oq, ri, rq;
        di = longint'($signed(d[15:0])); dq = longint'($signed(d[31:16]));
        oi = longint'($signed(o[15:0])); oq = longint'($signed(o[31:16]));
        ri = rs(di * oi - dq * oq);
        rq = rs(di * oq + dq * oi);
        case (m)
            2'd0: return d;
            2'd1: return {rq[15:0], ri[15:0]};
            2'd2: return o;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0; reg_addr = '0;
    endtask

    // Drives one beat at a falling edge; returns at the falling edge after acceptance.
    task automatic send(input logic [31:0] d, input logic [31:0] o);
        s_d_data = d; s_o_data = o; s_d_valid = 1'b1; s_o_valid = 1'b1;
        #1;
        while (!(s_d_ready && s_o_ready)) begin
            @(negedge clk); #1;
        end
        @(negedge clk);
        s_d_valid = 1'b0; s_o_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 m_valid", {31'b0, m_valid}, 32'h0);
        reg_addr = 4'h0; #1;
        check("R1 mode", reg_rdata, 32'h0);

        // R2 reserved bits dropped, other offsets ignored
        wr(4'h0, 32'hFFFF_FFFE); #1;
        check("R2 readback", reg_rdata, 32'h2);
        wr(4'h4, 32'h0000_0003);
        reg_addr = 4'h4; #1;
        check("R2 other read", reg_rdata, 32'h0);
        reg_addr = 4'h0; #1;
        check("R2 other write", reg_rdata, 32'h2);

        // Vector table: R3 R4 R5 R6 with R9 timing
        for (int k = 0; k < NV; k++) begin
            wr(4'h0, {30'b0, VEC[k][65:64]});
            @(negedge clk);
            send(VEC[k][63:32], VEC[k][31:0]);
            check("R9 not early", {31'b0, m_valid}, 32'h0);
            @(negedge clk);
            check("R9 valid", {31'b0, m_valid}, 32'h1);
            case (VEC[k][65:64])
                2'd0: check("R3 pass", m_data, model(2'd0, VEC[k][63:32], VEC[k][31:0]));
                2'd1: check("R4 mix", m_data, model(2'd1, VEC[k][63:32], VEC[k][31:0]));
                2'd2: check("R5 osc", m_data, model(2'd2, VEC[k][63:32], VEC[k][31:0]));
                default: check("R6 zero", m_data, 32'h0);
            endcase
            @(negedge clk);
        end

        // R4 directed: saturation and half-up rounding
        wr(4'h0, 32'h1);
        @(negedge clk); send(32'h8000_8000, 32'h8000_8000); @(negedge clk);
        check("R4 saturate", m_data, 32'h7FFF_0000);
        @(negedge clk); send(32'h0000_0001, 32'h0000_4000); @(negedge clk);
        check("R4 round up", m_data, 32'h0000_0001);
        @(negedge clk); send(32'h0000_FFFF, 32'h0000_4000); @(negedge clk);
        check("R4 round neg", m_data, 32'h0000_0000);
        @(negedge clk);

        // R7 one input alone is never taken
        s_d_data = 32'h5555_5555; s_d_valid = 1'b1;
        #1;
        check("R7 ready low", {31'b0, s_d_ready}, 32'h0);
        repeat (3) @(negedge clk);
        check("R7 no beat", {31'b0, m_valid}, 32'h0);
        s_d_valid = 1'b0;
        s_o_valid = 1'b1; #1;
        check("R7 osc ready low", {31'b0, s_o_ready}, 32'h0);
        s_o_valid = 1'b0;

        // R8 backpressure with two beats in flight
        wr(4'h0, 32'h0);
        @(negedge clk);
        m_ready = 1'b0;
        send(32'hAAAA_0001, 32'h0);
        send(32'hBBBB_0002, 32'h0);
        s_d_valid = 1'b1; s_o_valid = 1'b1; s_d_data = 32'hCCCC_0003;
        repeat (3) @(negedge clk);
        #1;
        check("R8 stall ready", {31'b0, s_d_ready}, 32'h0);
        check("R8 hold valid", {31'b0, m_valid}, 32'h1);
        check("R8 hold data", m_data, 32'hAAAA_0001);
        s_d_valid = 1'b0; s_o_valid = 1'b0;
        m_ready = 1'b1;
        @(negedge clk);
        check("R8 order", m_data, 32'hBBBB_0002);
        @(negedge clk);
        check("R8 drain", {31'b0, m_valid}, 32'h0);

        // R10 mode write on the acceptance edge
        wr(4'h0, 32'h1);
        @(negedge clk);
        s_d_data = 32'h0000_4000; s_o_data = 32'h0000_4000;
        s_d_valid = 1'b1; s_o_valid = 1'b1;
        reg_wen = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h3;
        @(negedge clk);
        s_d_valid = 1'b0; s_o_valid = 1'b0; reg_wen = 1'b0;
        @(negedge clk);
        check("R10 old mode", m_data, model(2'd1, 32'h0000_4000, 32'h0000_4000));
        @(negedge clk);
        send(32'h0000_4000, 32'h0000_4000);
        @(negedge clk);
        check("R10 new mode", m_data, 32'h0);
        check("R6 beat kept", {31'b0, m_valid}, 32'h1);
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule